// File: doc/BRIEF.md
# Banked Home-Computer I/O Port Decoder

This block sits between an 8-bit CPU's I/O bus and the peripherals of a banked-memory home computer. It watches a 16-bit port address together with read and write strobes and raises a chip select for each device the address hits. The decode is partial, so many addresses alias onto each port. The devices are the video/keyboard port, the memory paging latch, the two ports of the sound generator, and the floppy controller. The masks and the set of devices that are fitted depend on a machine-variant parameter. The variants are ordered from oldest to newest: base, banked, banked-second, newer and newer-disk.

The block also holds the paging register itself. The register has a sticky lock. When a value with bit 5 set is written, the latch keeps that value and ignores every later write until reset. On reads, the block combines the data of every device that responds. If nothing responds on one of the older machines, it returns the floating-bus byte supplied from outside.

Top module: `io_port_decoder`

## Requirements
- R1: `vid_cs` is high while a read or write strobe is active and address bit 0 is 0, whatever the upper address bits hold.
- R2: On the banked and banked-second variants, `page_cs` is high during a write when `(addr & 16'h8002) == 16'h0000`.
- R3: On the newer and newer-disk variants, `page_cs` is high during a write only when `(addr & 16'hC002) == 16'h4000`.
- R4: On every variant except base, `snd_sel_cs` is high during a read or write with `(addr & 16'hC002) == 16'hC000`. On the same variants, `snd_dat_cs` is high during a write with that masked value equal to `16'h8000`.
- R5: On the newer-disk variant only, `fdc_cs` is high during a read or write with `(addr & 16'hF002)` equal to `16'h2000` or `16'h3000`. `fdc_reg` then equals address bit 12, and it is 0 whenever `fdc_cs` is low.
- R6: While unlocked, a write with `page_cs` high loads `wdata` into `page_q` at that clock edge.
- R7: A latch write with `wdata[5]` set still loads its value and sets `page_locked` at the same edge. While `page_locked` is set, `page_q` ignores all further writes.
- R8: Synchronous reset clears `page_q` to 0 and `page_locked` to 0.
- R9: On a read, `rdata` starts at 8'hFF and is the bitwise AND of the data of every responding device. The responders are video (`vid_rdata`), the sound register-select port (`snd_rdata`) and the floppy controller (`fdc_rdata`).
- R10: On the base, banked and banked-second variants, a read that no device answers returns `float_rdata`. On the newer variants the same read returns 8'hFF.
- R11: With neither strobe active, all chip selects are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 16 | I/O port address |
| wr_en | input | 1 | I/O write strobe |
| rd_en | input | 1 | I/O read strobe |
| wdata | input | 8 | Write data |
| vid_rdata | input | 8 | Read data from the video/keyboard port |
| snd_rdata | input | 8 | Read data from the sound generator |
| fdc_rdata | input | 8 | Read data from the floppy controller |
| float_rdata | input | 8 | Floating-bus byte from the video fetch |
| vid_cs | output | 1 | Video/keyboard port select |
| page_cs | output | 1 | Paging latch write select |
| snd_sel_cs | output | 1 | Sound register-select port select |
| snd_dat_cs | output | 1 | Sound data-write port select |
| fdc_cs | output | 1 | Floppy controller select |
| fdc_reg | output | 1 | Floppy controller register index |
| page_q | output | 8 | Paging register contents |
| page_locked | output | 1 | Sticky paging lock |
| rdata | output | 8 | Merged read data |

## Verification
The decode paths have no state, so a wrong mask shows up in the same cycle as a chip select that is missing or that aliases onto the wrong device. The same fault can also show as a wrong merged read byte. The paging register and its lock are the only state. A fault there shows at `page_q` or `page_locked` one edge after the write that caused it. A lock that is set too early or never set shows at the next write to the latch, which must then either be held off or taken. Random addresses mixed with rare lock-setting values and periodic resets keep both of these paths exercised on an old-mask variant and a new-mask variant side by side.

// File: rtl/io_dec_pkg.sv
package io_dec_pkg;

    localparam int ADDR_W   = 16;
    localparam int DATA_W   = 8;
    localparam int LOCK_BIT = 5;
    localparam int N_RDDEV  = 3;

    typedef enum logic [2:0] {
        VAR_BASE    = 3'd0,
        VAR_BANKED  = 3'd1,
        VAR_BANKED2 = 3'd2,
        VAR_NEWER   = 3'd3,
        VAR_DISK    = 3'd4
    } variant_e;

    typedef struct packed {
        logic vid;
        logic page;
        logic snd_sel;
        logic snd_dat;
        logic fdc;
    } sel_t;

    function automatic logic is_banked(variant_e v);
        return v != VAR_BASE;
    endfunction

    function automatic logic uses_old_mask(variant_e v);
        return (v == VAR_BANKED) || (v == VAR_BANKED2);
    endfunction

    function automatic logic floats(variant_e v);
        return v <= VAR_BANKED2;
    endfunction

    function automatic logic page_hit(variant_e v, logic [ADDR_W-1:0] a);
        if (!is_banked(v))
            return 1'b0;
        if (uses_old_mask(v))
            return (a & 16'h8002) == 16'h0000;
        return (a & 16'hC002) == 16'h4000;
    endfunction

    function automatic logic snd_sel_hit(variant_e v, logic [ADDR_W-1:0] a);
        return is_banked(v) && ((a & 16'hC002) == 16'hC000);
    endfunction

    function automatic logic snd_dat_hit(variant_e v, logic [ADDR_W-1:0] a);
        return is_banked(v) && ((a & 16'hC002) == 16'h8000);
    endfunction

    function automatic logic fdc_hit(variant_e v, logic [ADDR_W-1:0] a);
        logic [ADDR_W-1:0] m;
        m = a & 16'hF002;
        return (v == VAR_DISK) && ((m == 16'h2000) || (m == 16'h3000));
    endfunction

endpackage

// File: rtl/io_addr_match.sv
module io_addr_match
    import io_dec_pkg::*;
#(
    parameter variant_e VARIANT = VAR_DISK
) (
    input  logic [ADDR_W-1:0]  addr,
    input  logic               wr_en,
    input  logic               rd_en,
    output sel_t               wsel,
    output logic [N_RDDEV-1:0] rhit
);
    logic any_en;
    assign any_en = wr_en | rd_en;

    always_comb begin
        wsel.vid     = wr_en & ~addr[0];
        wsel.page    = wr_en & page_hit(VARIANT, addr);
        wsel.snd_sel = wr_en & snd_sel_hit(VARIANT, addr);
        wsel.snd_dat = wr_en & snd_dat_hit(VARIANT, addr);
        wsel.fdc     = wr_en & fdc_hit(VARIANT, addr);
        // read responders: video, sound register port, floppy
        rhit[0] = rd_en & ~addr[0];
        rhit[1] = rd_en & snd_sel_hit(VARIANT, addr);
        rhit[2] = rd_en & fdc_hit(VARIANT, addr) & any_en;
    end
endmodule

// File: rtl/io_page_latch.sv
module io_page_latch
    import io_dec_pkg::*;
#(
    parameter int WIDTH = DATA_W,
    parameter int LOCK  = LOCK_BIT
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_hit,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] page_q,
    output logic             locked
);
    logic take;
    assign take = wr_hit & ~locked;

    always_ff @(posedge clk) begin
        if (rst) begin
            page_q <= '0;
            locked <= 1'b0;
        end else if (take) begin
            page_q <= wdata;
            locked <= wdata[LOCK];
        end
    end
endmodule

// File: rtl/io_read_merge.sv
module io_read_merge
    import io_dec_pkg::*;
#(
    parameter int WIDTH = DATA_W,
    parameter int NDEV  = N_RDDEV
) (
    input  logic [NDEV-1:0]            hit,
    input  logic [NDEV-1:0][WIDTH-1:0] dev_data,
    input  logic                       float_en,
    input  logic [WIDTH-1:0]           float_data,
    output logic [WIDTH-1:0]           rdata
);
    logic [NDEV:0][WIDTH-1:0] acc;
    assign acc[0] = '1;

    for (genvar i = 0; i < NDEV; i++) begin : g_and
        assign acc[i+1] = hit[i] ? (acc[i] & dev_data[i]) : acc[i];
    end

    assign rdata = (float_en && hit == '0) ? float_data : acc[NDEV];
endmodule

// File: rtl/io_port_decoder.sv
module io_port_decoder
    import io_dec_pkg::*;
#(
    parameter variant_e VARIANT = VAR_DISK
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] vid_rdata,
    input  logic [DATA_W-1:0] snd_rdata,
    input  logic [DATA_W-1:0] fdc_rdata,
    input  logic [DATA_W-1:0] float_rdata,
    output logic              vid_cs,
    output logic              page_cs,
    output logic              snd_sel_cs,
    output logic              snd_dat_cs,
    output logic              fdc_cs,
    output logic              fdc_reg,
    output logic [DATA_W-1:0] page_q,
    output logic              page_locked,
    output logic [DATA_W-1:0] rdata
);
    localparam logic FLOAT_EN = floats(VARIANT);

    sel_t               wsel;
    logic [N_RDDEV-1:0] rhit;

    io_addr_match #(.VARIANT(VARIANT)) u_match (
        .addr  (addr),
        .wr_en (wr_en),
        .rd_en (rd_en),
        .wsel  (wsel),
        .rhit  (rhit)
    );

    assign vid_cs     = wsel.vid | rhit[0];
    assign page_cs    = wsel.page;
    assign snd_sel_cs = wsel.snd_sel | rhit[1];
    assign snd_dat_cs = wsel.snd_dat;
    assign fdc_cs     = wsel.fdc | rhit[2];
    assign fdc_reg    = fdc_cs & addr[12];

    if (VARIANT == VAR_BASE) begin : g_no_page
        assign page_q      = '0;
        assign page_locked = 1'b0;
    end else begin : g_page
        io_page_latch #(.WIDTH(DATA_W), .LOCK(LOCK_BIT)) u_page (
            .clk    (clk),
            .rst    (rst),
            .wr_hit (wsel.page),
            .wdata  (wdata),
            .page_q (page_q),
            .locked (page_locked)
        );
    end

    io_read_merge #(.WIDTH(DATA_W), .NDEV(N_RDDEV)) u_merge (
        .hit        (rhit),
        .dev_data   ({fdc_rdata, snd_rdata, vid_rdata}),
        .float_en   (FLOAT_EN),
        .float_data (float_rdata),
        .rdata      (rdata)
    );
endmodule

module io_port_decoder_chk
    import io_dec_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic              rd_en,
    input logic [DATA_W-1:0] wdata,
    input logic              vid_cs,
    input logic              page_cs,
    input logic              snd_sel_cs,
    input logic              snd_dat_cs,
    input logic              fdc_cs,
    input logic [DATA_W-1:0] page_q,
    input logic              page_locked
);
    // R6
    page_load_chk: assert property (@(posedge clk) disable iff (rst)
        (page_cs && !page_locked) |=> (page_q == $past(wdata)));

    // R7
    lock_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        page_locked |=> page_locked);

    // R7
    locked_hold_chk: assert property (@(posedge clk) disable iff (rst)
        page_locked |=> $stable(page_q));

    // R8
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (page_q == '0 && !page_locked));

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !(wr_en || rd_en) |-> !(vid_cs || page_cs || snd_sel_cs || snd_dat_cs || fdc_cs));

    // R4
    excl_dev_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({page_cs, snd_sel_cs, snd_dat_cs, fdc_cs}));
endmodule

bind io_port_decoder io_port_decoder_chk u_chk (.*);

// File: tb/io_port_decoder_test.sv
module io_port_decoder_test;
    import io_dec_pkg::*;

    localparam int PERIOD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [15:0] addr = '0;
    logic wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] wdata = '0, vid_d = '0, snd_d = '0, fdc_d = '0, flt_d = '0;

    logic n_vid, n_pg, n_ss, n_sd, n_fdc, n_reg, n_lk;
    logic [7:0] n_pq, n_rd;
    logic o_vid, o_pg, o_ss, o_sd, o_fdc, o_reg, o_lk;
    logic [7:0] o_pq, o_rd;

    int checks = 0, errors = 0;
    logic [7:0] m_page [2];
    logic       m_lock [2];

    always #(PERIOD/2) clk = ~clk;

    io_port_decoder #(.VARIANT(VAR_DISK)) uut (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata),
        .vid_rdata(vid_d), .snd_rdata(snd_d), .fdc_rdata(fdc_d), .float_rdata(flt_d),
        .vid_cs(n_vid), .page_cs(n_pg), .snd_sel_cs(n_ss), .snd_dat_cs(n_sd), .fdc_cs(n_fdc),
        .fdc_reg(n_reg), .page_q(n_pq), .page_locked(n_lk), .rdata(n_rd));

    io_port_decoder #(.VARIANT(VAR_BANKED2)) uut_old (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata),
        .vid_rdata(vid_d), .snd_rdata(snd_d), .fdc_rdata(fdc_d), .float_rdata(flt_d),
        .vid_cs(o_vid), .page_cs(o_pg), .snd_sel_cs(o_ss), .snd_dat_cs(o_sd), .fdc_cs(o_fdc),
        .fdc_reg(o_reg), .page_q(o_pq), .page_locked(o_lk), .rdata(o_rd));

    task automatic cmp(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h addr=%h wr=%b rd=%b t=%0t",
                     tag, act, exp, addr, wr_en, rd_en, $time);
        end
    endtask

    // {vid, page, snd_sel, snd_dat, fdc, fdc_reg}
    function automatic logic [5:0] exp_cs(bit newer, logic [15:0] a, logic w, logic r);
        logic any, v, p, s, d, f;
        any = w | r;
        v = any & ~a[0];
        p = w & (newer ? ((a & 16'hC002) == 16'h4000) : ((a & 16'h8002) == 16'h0000));
        s = any & ((a & 16'hC002) == 16'hC000);
        d = w & ((a & 16'hC002) == 16'h8000);
        f = newer & any & (((a & 16'hF002) == 16'h2000) || ((a & 16'hF002) == 16'h3000));
        return {v, p, s, d, f, f & a[12]};
    endfunction

    function automatic logic [7:0] exp_rd(bit newer, logic [15:0] a);
        logic [7:0] m;
        bit hit;
        m = 8'hFF; hit = 0;
        if (!a[0]) begin m &= vid_d; hit = 1; end
        if ((a & 16'hC002) == 16'hC000) begin m &= snd_d; hit = 1; end
        if (newer && (((a & 16'hF002) == 16'h2000) || ((a & 16'hF002) == 16'h3000))) begin
            m &= fdc_d; hit = 1;
        end
        if (!hit && !newer) return flt_d;
        return m;
    endfunction

    function automatic string rtag(bit newer, logic [15:0] a);
        logic [5:0] e;
        e = exp_cs(newer, a, 1'b0, 1'b1);
        return (e[5] | e[3] | e[1]) ? "R9" : "R10";
    endfunction

    task automatic check_state();
        cmp(m_lock[0] ? "R7 new page_q" : "R6 new page_q", n_pq, m_page[0]);
        cmp(m_lock[1] ? "R7 old page_q" : "R6 old page_q", o_pq, m_page[1]);
        cmp("R7 new lock", {7'd0, n_lk}, {7'd0, m_lock[0]});
        cmp("R7 old lock", {7'd0, o_lk}, {7'd0, m_lock[1]});
    endtask

    task automatic step(logic [15:0] a, logic w, logic r, logic [7:0] d);
        logic [5:0] en, eo;
        string idle;
        @(negedge clk);
        check_state();
        addr = a; wr_en = w; rd_en = r; wdata = d;
        vid_d = 8'($urandom); snd_d = 8'($urandom); fdc_d = 8'($urandom); flt_d = 8'($urandom);
        #(PERIOD/4);
        en = exp_cs(1'b1, a, w, r);
        eo = exp_cs(1'b0, a, w, r);
        idle = (!w && !r) ? "R11 " : "";
        cmp({idle, "R1 vid new"}, {7'd0, n_vid}, {7'd0, en[5]});
        cmp({idle, "R1 vid old"}, {7'd0, o_vid}, {7'd0, eo[5]});
        cmp({idle, "R3 page new"}, {7'd0, n_pg}, {7'd0, en[4]});
        cmp({idle, "R2 page old"}, {7'd0, o_pg}, {7'd0, eo[4]});
        cmp({idle, "R4 snd new"}, {6'd0, n_ss, n_sd}, {6'd0, en[3:2]});
        cmp({idle, "R4 snd old"}, {6'd0, o_ss, o_sd}, {6'd0, eo[3:2]});
        cmp({idle, "R5 fdc new"}, {6'd0, n_fdc, n_reg}, {6'd0, en[1:0]});
        cmp({idle, "R5 fdc old"}, {6'd0, o_fdc, o_reg}, {6'd0, eo[1:0]});
        if (r) begin
            cmp({rtag(1'b1, a), " rdata new"}, n_rd, exp_rd(1'b1, a));
            cmp({rtag(1'b0, a), " rdata old"}, o_rd, exp_rd(1'b0, a));
        end
        @(posedge clk);
        if (en[4] && !m_lock[0]) begin m_page[0] = d; m_lock[0] = d[5]; end
        if (eo[4] && !m_lock[1]) begin m_page[1] = d; m_lock[1] = d[5]; end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0;
        @(posedge clk);
        for (int i = 0; i < 2; i++) begin m_page[i] = '0; m_lock[i] = 1'b0; end
        @(negedge clk);
        rst = 1'b0;
        // R8 reset state
        cmp("R8 new page_q", n_pq, 8'h00);
        cmp("R8 old page_q", o_pq, 8'h00);
        cmp("R8 locks", {6'd0, n_lk, o_lk}, 8'h00);
    endtask

    initial begin
        #(PERIOD * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        do_reset();
        // directed corner cases
        step(16'h7FFD, 1, 0, 8'h03);   // R2 R3 both masks hit
        step(16'h3FFD, 1, 0, 8'h11);   // R2 old only, R5 fdc reg 1
        step(16'h2FFD, 0, 1, 8'h00);   // R5 fdc reg 0 read
        step(16'hBFFD, 1, 0, 8'h0E);   // R4 data port
        step(16'hFFFD, 0, 1, 8'h00);   // R4 select read, R9
        step(16'hFFFC, 0, 1, 8'h00);   // R9 two responders
        step(16'h00FF, 0, 1, 8'h00);   // R10 no responder
        step(16'h7FFD, 0, 0, 8'h55);   // R11 idle
        step(16'h7FFD, 1, 0, 8'h27);   // R7 lock with value
        step(16'h7FFD, 1, 0, 8'h03);   // R7 ignored
        step(16'h0000, 0, 0, 8'h00);
        do_reset();                    // R8 clears lock
        step(16'h7FFD, 1, 0, 8'h05);   // R6 loads again
        for (int i = 0; i < 2000; i++) begin
            logic [1:0] op;
            logic [7:0] d;
            if (i % 250 == 249) do_reset();
            op = 2'($urandom_range(0, 3));
            d = 8'($urandom);
            if ($urandom_range(0, 15) != 0) d[5] = 1'b0;
            step(16'($urandom), op == 1 || op == 3, op == 2, d);
        end
        @(negedge clk);
        check_state();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule